// File: doc/BRIEF.md
# Sync-Spreading Frame Interleaver

This block collects one frame of encoded channel symbols into a 5200-bit buffer organised as 80 rows of 65 bits, then emits the buffer column by column as a serial bit stream for the line encoders that follow. Rows 1 to 79 take the encoded symbols in row order, starting at row 1, column 0. Row 0 is not stored. While the buffer drains, a 7-bit linear feedback shift register produces it, so a 65-bit synchronisation pattern ends up spread across the frame. Each transmitted column starts with one pattern bit, followed by the 79 symbols beneath it.

A frame holds 5132 symbols, which leaves three buffer slots with no data. These slots go out as zeros. The input side accepts symbols only while the buffer is filling and shows this on a ready output. Once the last symbol of a frame arrives, the block switches to draining. It sends all 5200 bits under a valid/ready handshake and flags the first bit of each frame. After the last bit is accepted, it accepts input again.

Top module: `sync_spread_interleaver`

## Requirements
- R1: After reset, `outValid` and `outFrameStart` are 0 and `inReady` is 1.
- R2: Symbol number k of a frame (0-based) is stored at row 1 + k/65, column k mod 65. Output bit number p of the frame (0-based) is read from column p/80, row p mod 80. Each column is sent top to bottom, and the columns are sent left to right.
- R3: The bit sent for row 0 of column c is bit c of the 65-bit pattern from the recurrence s[n+7] = s[n+3] xor s[n], seeded with seven ones (pattern starts 1111111 0000111). The pattern is the same in every frame.
- R4: The three slots that follow symbol 5131 (row 79, columns 62 to 64, at output positions 5039, 5119 and 5199) are always sent as 0.
- R5: `outFrameStart` is 1 while output bit 0 of a frame is offered, and 0 for every other offered bit.
- R6: While a frame drains, `inReady` is 0 and input symbols are ignored, so they cannot alter the frame being sent.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outBit` holds its value at the next cycle.
- R8: A symbol accepted with `symFirst` set becomes symbol 0 of a new frame, and any partly filled frame is discarded.
- R9: `outValid` rises in the cycle after the 5132nd symbol is accepted. `inReady` returns to 1, and `outValid` falls, in the cycle after output bit 5199 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Input symbol present |
| symBit | input | 1 | Encoded symbol value |
| symFirst | input | 1 | Marks symbol 0 of a frame |
| inReady | output | 1 | Block accepts symbols (filling) |
| outValid | output | 1 | Serial output bit present (draining) |
| outBit | output | 1 | Serial output bit |
| outFrameStart | output | 1 | First bit of the 5200-bit frame |
| outReady | input | 1 | Downstream accepts the output bit |

## Verification
Each kind of internal fault shows at the ports in its own way. A wrong write address corrupts specific data bits, and those bits appear at output positions that can be predicted from the column-major mapping. A miscounted fill moves the rise of `outValid` earlier or later than the cycle after symbol 5132. A faulty pattern generator corrupts bit 0 of some column, and an error in the first column shows within the first output bit. A faulty read counter puts data in the wrong order, or flags the frame start on the wrong bit, within the first 80 bits. Write protection that fails during draining shows as changed data before that same frame finishes. The bench uses random data, random input gaps and random output back-pressure, so each of these faults leads to a mismatch against the bit positions computed in the bench.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int ILV_COLS    = 65;
  localparam int ILV_ROWS    = 80;
  localparam int ILV_PAYLOAD = 5132;
  localparam int SYNC_W      = 7;
  localparam int SYNC_TAP    = 3;
  localparam int ILV_SLOTS   = ILV_COLS * ILV_ROWS;
  localparam int ROW_W       = $clog2(ILV_ROWS + 1);
  localparam int COL_W       = $clog2(ILV_COLS + 1);
  localparam int CNT_W       = $clog2(ILV_SLOTS + 1);
  localparam logic [SYNC_W-1:0] SYNC_SEED = '1;

  typedef enum logic {ST_FILL, ST_DRAIN} ilvState_e;

  typedef struct packed {
    logic             wrEn;
    logic [ROW_W-1:0] wrRow;
    logic [COL_W-1:0] wrCol;
    logic [ROW_W-1:0] rdRow;
    logic [COL_W-1:0] rdCol;
    logic             syncSel;
    logic             syncBit;
    logic             padSel;
  } ilvStrobe_t;
endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       symValid,
  input  logic       symFirst,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output logic       outFrameStart,
  output ilvStrobe_t strobe
);
  ilvState_e         state;
  logic [CNT_W-1:0]  wrCount;
  logic              frameOpen;
  logic [ROW_W-1:0]  wrRow, baseRow, rdRow;
  logic [COL_W-1:0]  wrCol, baseCol, rdCol;
  logic [SYNC_W-1:0] lfsr;
  logic [CNT_W-1:0]  nextCount, rdLin;
  logic              takeSym, frameDone, outXfer, baseLastCol, rdLastRow, rdLastCol;

  always_comb begin
    takeSym     = (state == ST_FILL) && symValid && (symFirst || frameOpen);
    baseRow     = symFirst ? ROW_W'(1) : wrRow;
    baseCol     = symFirst ? '0 : wrCol;
    nextCount   = symFirst ? CNT_W'(1) : wrCount + CNT_W'(1);
    baseLastCol = (baseCol == COL_W'(ILV_COLS - 1));
    frameDone   = takeSym && (nextCount == CNT_W'(ILV_PAYLOAD));
    outXfer     = (state == ST_DRAIN) && outReady;
    rdLastRow   = (rdRow == ROW_W'(ILV_ROWS - 1));
    rdLastCol   = (rdCol == COL_W'(ILV_COLS - 1));
    rdLin       = (CNT_W'(rdRow) - CNT_W'(1)) * CNT_W'(ILV_COLS) + CNT_W'(rdCol);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_FILL;
      wrCount   <= '0;
      frameOpen <= 1'b0;
      wrRow     <= ROW_W'(1);
      wrCol     <= '0;
      rdRow     <= '0;
      rdCol     <= '0;
      lfsr      <= SYNC_SEED;
    end else begin
      if (takeSym) begin
        wrCount   <= nextCount;
        frameOpen <= 1'b1;
        if (baseLastCol) begin
          wrRow <= baseRow + ROW_W'(1);
          wrCol <= '0;
        end else begin
          wrRow <= baseRow;
          wrCol <= baseCol + COL_W'(1);
        end
      end
      if (frameDone) begin
        state     <= ST_DRAIN;
        frameOpen <= 1'b0;
        rdRow     <= '0;
        rdCol     <= '0;
        lfsr      <= SYNC_SEED;
      end
      if (outXfer) begin
        if (rdRow == '0) lfsr <= {lfsr[0] ^ lfsr[SYNC_TAP], lfsr[SYNC_W-1:1]};
        if (rdLastRow) begin
          rdRow <= '0;
          if (rdLastCol) state <= ST_FILL;
          else           rdCol <= rdCol + COL_W'(1);
        end else begin
          rdRow <= rdRow + ROW_W'(1);
        end
      end
    end
  end

  assign inReady       = (state == ST_FILL);
  assign outValid      = (state == ST_DRAIN);
  assign outFrameStart = outValid && (rdRow == '0) && (rdCol == '0);

  always_comb begin
    strobe.wrEn    = takeSym;
    strobe.wrRow   = baseRow;
    strobe.wrCol   = baseCol;
    strobe.rdRow   = rdRow;
    strobe.rdCol   = rdCol;
    strobe.syncSel = (rdRow == '0);
    strobe.syncBit = lfsr[0];
    strobe.padSel  = (rdRow != '0) && (rdLin >= CNT_W'(ILV_PAYLOAD));
  end

  AST_DRAIN_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outFrameStart && (lfsr == SYNC_SEED)); // R5
  AST_NO_WRITE_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !strobe.wrEn); // R6
  AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(rdLastRow) && $past(rdLastCol) && $past(outReady) && inReady); // R9
endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrBit,
  input  ilvStrobe_t strobe,
  output logic       outBit
);
  logic [ILV_COLS-1:0] rowView [ILV_ROWS];
  logic                rdBit;

  assign rowView[0] = '0;

  for (genvar r = 1; r < ILV_ROWS; r++) begin : g_row
    logic [ILV_COLS-1:0] rowBits;
    always_ff @(posedge clk) begin
      if (strobe.wrEn && (strobe.wrRow == ROW_W'(r))) rowBits[strobe.wrCol] <= wrBit;
    end
    assign rowView[r] = rowBits;
  end

  assign rdBit  = rowView[strobe.rdRow][strobe.rdCol];
  assign outBit = strobe.syncSel ? strobe.syncBit : (strobe.padSel ? 1'b0 : rdBit);

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (strobe.wrRow >= ROW_W'(1)) && (strobe.wrRow < ROW_W'(ILV_ROWS))
                    && (strobe.wrCol < COL_W'(ILV_COLS))); // R2
endmodule

// File: rtl/sync_spread_interleaver.sv
module sync_spread_interleaver
  import ilv_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic symValid,
  input  logic symBit,
  input  logic symFirst,
  output logic inReady,
  output logic outValid,
  output logic outBit,
  output logic outFrameStart,
  input  logic outReady
);
  ilvStrobe_t strobe;

  ilv_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symFirst(symFirst),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .outFrameStart(outFrameStart), .strobe(strobe)
  );

  ilv_datapath i_datapath (
    .clk(clk), .rstN(rstN), .wrBit(symBit), .strobe(strobe), .outBit(outBit)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outBit)); // R7
endmodule

// File: tb/test_sync_spread_interleaver.sv
module test_sync_spread_interleaver;
  localparam int COLS  = 65;
  localparam int ROWS  = 80;
  localparam int PAY   = 5132;
  localparam int SLOTS = COLS * ROWS;

  logic clk = 1'b0, rstN = 1'b0;
  logic symValid = 1'b0, symBit = 1'b0, symFirst = 1'b0, outReady = 1'b0;
  logic inReady, outValid, outBit, outFrameStart;

  int nChecks = 0;
  int nFail   = 0;
  bit symMem [PAY];
  logic [64:0] syncRef = 65'b11111110000111011110010110010010000001000100110001011101011011000;

  always #2 clk = ~clk;

  sync_spread_interleaver i_sync_spread_interleaver (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symBit(symBit), .symFirst(symFirst),
    .inReady(inReady), .outValid(outValid), .outBit(outBit),
    .outFrameStart(outFrameStart), .outReady(outReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expBit(input int pos);
    int c = pos / ROWS;
    int r = pos % ROWS;
    int k = (r - 1) * COLS + c;
    if (r == 0) return syncRef[64 - c];
    if (k >= PAY) return 1'b0;
    return symMem[k];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R9 watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  // R8: pre symbols start a partial frame that the real frame restarts
  task automatic fillFrame(input int mode, input int gapPct, input int pre);
    for (int k = 0; k < pre; k++) begin
      symValid = 1'b1; symBit = 1'($urandom % 2); symFirst = (k == 0);
      @(negedge clk);
    end
    for (int k = 0; k < PAY; k++) begin
      symMem[k] = (mode == 0) ? 1'($urandom % 2) : (mode == 2);
      if (int'($urandom % 100) < gapPct) begin
        symValid = 1'b0; symFirst = 1'b0;
        @(negedge clk);
      end
      symValid = 1'b1; symBit = symMem[k]; symFirst = (k == 0);
      @(negedge clk);
    end
    symValid = 1'b0; symFirst = 1'b0;
    check(outValid === 1'b1 && inReady === 1'b0, "R9 R8 drain one cycle after symbol 5132",
          int'(outValid), 1);
  endtask

  task automatic drainFrame(input int readyPct, input bit junk);
    int pos = 0;
    int dataErr = 0, syncErr = 0, padErr = 0, fsErr = 0, stallErr = 0, lockErr = 0;
    int firstBad = -1;
    bit prevStall = 1'b0, prevBit = 1'b0;
    while (pos < SLOTS) begin
      outReady = (int'($urandom % 100) < readyPct);
      if (junk) begin
        symValid = 1'($urandom % 2); symBit = 1'($urandom % 2); symFirst = 1'($urandom % 2);
      end
      if (prevStall && (outBit !== prevBit || outValid !== 1'b1)) stallErr++;
      if (inReady !== 1'b0 || outValid !== 1'b1) lockErr++;
      if (outReady) begin
        if (outBit !== expBit(pos)) begin
          if (firstBad < 0) firstBad = pos;
          if (pos % ROWS == 0) syncErr++;
          else if ((pos % ROWS - 1) * COLS + pos / ROWS >= PAY) padErr++;
          else dataErr++;
        end
        if (outFrameStart !== (pos == 0)) fsErr++;
        pos++;
        prevStall = 1'b0;
      end else begin
        prevStall = 1'b1;
        prevBit = outBit;
      end
      @(negedge clk);
    end
    symValid = 1'b0; symFirst = 1'b0; outReady = 1'b0;
    check(dataErr == 0, "R2 data bit errors (first bad position in log)", dataErr, 0);
    if (dataErr != 0) $display("  first mismatching position %0d", firstBad);
    check(syncErr == 0, "R3 pattern bit errors", syncErr, 0);
    check(padErr == 0, "R4 unused slot errors", padErr, 0);
    check(fsErr == 0, "R5 frame start flag errors", fsErr, 0);
    check(stallErr == 0, "R7 stall hold errors", stallErr, 0);
    check(lockErr == 0, "R6 input not locked during drain", lockErr, 0);
    check(inReady === 1'b1 && outValid === 1'b0, "R9 fill resumes after bit 5199",
          int'(inReady), 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a40));
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R1 outValid in reset", int'(outValid), 0);
    check(inReady === 1'b1, "R1 inReady in reset", int'(inReady), 1);
    check(outFrameStart === 1'b0, "R1 outFrameStart in reset", int'(outFrameStart), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0 && inReady === 1'b1, "R1 idle after reset", int'(outValid), 0);

    fillFrame(0, 30, 0);
    drainFrame(60, 1'b1);
    fillFrame(1, 0, 300);
    drainFrame(100, 1'b0);
    fillFrame(2, 10, 0);
    drainFrame(40, 1'b1);
    fillFrame(0, 0, 17);
    drainFrame(100, 1'b1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule